// File: doc/BRIEF.md
# Converter Power-Up and Initialization Sequencer

This block controls the digital reset and start-up of a stereo audio converter core. An active-low power-down input holds the core in reset. When power-down is released, the block waits until both the master clock and the frame (word-select) clock are seen toggling. It then counts a fixed number of frame-clock edges. For that whole window the outgoing sample stream is replaced by two's-complement zero. After the last counted edge the samples pass through unchanged and a ready flag is raised.

All control runs in a fast system clock domain. The power-down pin and both converter clocks are brought in through two-stage synchronizers. Each converter clock has its own watchdog counter, and a clock that shows no edge for `CLK_TIMEOUT` system cycles is treated as absent. Losing either clock while initializing or running sends the block back to waiting for clocks, with zeros forced. Returning to run then takes a fresh full count. The frame edge that is counted depends on the serial format. Left-justified framing counts rising edges and I2S framing counts falling edges.

The internal reset output clears the filter and serial transmitter. The zero-force flag and the gated sample output feed the transmitter's data path.

Top module: `pwrup_seq`

## Requirements
- R1: While `pwr_dn_n` is low, `core_rst` is 1, `zero_force` is 1 and `ready` is 0. A low level on the pin reaches these outputs no later than the third rising system-clock edge, from any state. It also clears the initialization count, so a later release needs the full count again.
- R2: After release with both clocks present, `zero_force` stays 1 and `ready` stays 0 until `INIT_FRAMES` (default 4129) counted frame edges have occurred. `ready` goes to 1 and `zero_force` to 0 on the third rising system-clock edge after the pin transition of the last counted edge, which is the cycle the block enters run.
- R3: With `fmt_i2s` = 0 only rising edges of `frame_in` are counted. With `fmt_i2s` = 1 only falling edges are counted.
- R4: After release, if either `mclk_in` or `frame_in` shows no edge for `CLK_TIMEOUT` (default 64) system cycles, the block stays in the wait-for-clocks condition. In that condition `core_rst` is 0, `zero_force` is 1 and `ready` is 0.
- R5: If either clock stops for more than `CLK_TIMEOUT` cycles during initialization or run, `ready` falls and `zero_force` rises. When the clocks return, a full count is needed before `ready` rises again.
- R6: `sample_out` equals `sample_in` when `zero_force` is 0 and is all zeros when `zero_force` is 1.
- R7: Right after system reset, `core_rst` = 1, `zero_force` = 1, `ready` = 0 and `sample_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| pwr_dn_n | input | 1 | Active-low power-down request, asynchronous |
| mclk_in | input | 1 | Converter master clock, sampled for presence |
| frame_in | input | 1 | Converter frame clock, sampled for presence and counted |
| fmt_i2s | input | 1 | 0: count rising frame edges, 1: count falling frame edges |
| sample_in | input | SAMPLE_W | Sample word from the filter |
| core_rst | output | 1 | Internal reset to filter and transmitter, active high |
| zero_force | output | 1 | 1 while output samples are forced to zero |
| ready | output | 1 | 1 once initialization has finished |
| sample_out | output | SAMPLE_W | Gated sample word |

## Verification
The assertions check several rules on every cycle. A held power-down always lands in reset. The init counter never passes its last value. `ready` can only rise after the counter has reached that last value. Leaving reset never jumps straight to run. `ready` is never high once either clock has been quiet past the timeout plus the synchronizer latency. Only the bench's scenarios can show the rest. These are the exact cycle `ready` rises relative to the last counted edge, the count running on the opposite frame edge in I2S framing, and the count restarting after a power-down in the middle of initialization.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WAIT_CLK = 2'd1,
        ST_INIT     = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pwrup_seq_sync.sv
module pwrup_seq_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage1 = async_in;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage2;

endmodule

// File: rtl/pwrup_seq_watch.sv
module pwrup_seq_watch #(
    parameter int CLK_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic alive
);

    localparam int CW = $clog2(CLK_TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CLK_TIMEOUT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] gap;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.prev = level;
        if (level != w_q.prev) begin
            w_d.gap = '0;
        end else if (w_q.gap != LIMIT) begin
            w_d.gap = w_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.prev <= 1'b0;
            w_q.gap  <= LIMIT;
        end else begin
            w_q <= w_d;
        end
    end

    assign alive = (w_q.gap != LIMIT);

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int INIT_FRAMES = 4129,
    parameter int CLK_TIMEOUT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn_n,
    input  logic                mclk_in,
    input  logic                frame_in,
    input  logic                fmt_i2s,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                core_rst,
    output logic                zero_force,
    output logic                ready,
    output logic [SAMPLE_W-1:0] sample_out
);

    localparam int CNT_W = $clog2(INIT_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);
    localparam int N_CLK = 2;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             frame_prev;
    } seq_t;

    seq_t s_d, s_q;

    logic [N_CLK:0]   sync_vec;
    logic [N_CLK-1:0] alive_v;
    logic             pd_n_s;
    logic             frame_s;
    logic             frame_edge;
    logic             clocks_ok;
    logic [CNT_W-1:0] init_cnt;

    pwrup_seq_sync #(.WIDTH(N_CLK + 1)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pwr_dn_n, mclk_in, frame_in}),
        .sync_out (sync_vec)
    );

    // bit 0 = frame clock, bit 1 = master clock
    for (genvar g = 0; g < N_CLK; g++) begin : g_watch
        pwrup_seq_watch #(.CLK_TIMEOUT(CLK_TIMEOUT)) i_watch (
            .clk   (clk),
            .rst_n (rst_n),
            .level (sync_vec[g]),
            .alive (alive_v[g])
        );
    end

    assign pd_n_s    = sync_vec[N_CLK];
    assign frame_s   = sync_vec[0];
    assign clocks_ok = &alive_v;
    assign frame_edge = fmt_i2s ? (s_q.frame_prev & ~frame_s)
                                : (~s_q.frame_prev & frame_s);

    always_comb begin
        s_d            = s_q;
        s_d.frame_prev = frame_s;
        unique case (s_q.state)
            ST_OFF: begin
                s_d.cnt = '0;
                s_d.state = ST_WAIT_CLK;
            end
            ST_WAIT_CLK: begin
                s_d.cnt = '0;
                if (clocks_ok) s_d.state = ST_INIT;
            end
            ST_INIT: begin
                if (!clocks_ok) begin
                    s_d.state = ST_WAIT_CLK;
                end else if (frame_edge) begin
                    if (s_q.cnt == LAST) s_d.state = ST_RUN;
                    else                 s_d.cnt   = s_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!clocks_ok) s_d.state = ST_WAIT_CLK;
            end
            default: s_d.state = ST_OFF;
        endcase
        if (!pd_n_s) begin
            s_d.state = ST_OFF;
            s_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state      <= ST_OFF;
            s_q.cnt        <= '0;
            s_q.frame_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign init_cnt   = s_q.cnt;
    assign core_rst   = (s_q.state == ST_OFF);
    assign ready      = (s_q.state == ST_RUN);
    assign zero_force = ~ready;
    assign sample_out = ready ? sample_in : '0;

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int INIT_FRAMES = 4129,
    parameter int CLK_TIMEOUT = 64,
    parameter int CNT_W       = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn_n,
    input logic             mclk_in,
    input logic             frame_in,
    input logic             core_rst,
    input logic             zero_force,
    input logic             ready,
    input logic [CNT_W-1:0] init_cnt
);

    localparam int GW = $clog2(CLK_TIMEOUT + 8) + 1;
    localparam logic [GW-1:0] GAP_MAX  = GW'(CLK_TIMEOUT + 6);
    localparam logic [GW-1:0] GAP_DEAD = GW'(CLK_TIMEOUT + 5);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(INIT_FRAMES - 1);

    logic          mclk_prev_q, frame_prev_q;
    logic [GW-1:0] mclk_gap_q, frame_gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_prev_q  <= 1'b0;
            frame_prev_q <= 1'b0;
            mclk_gap_q   <= '0;
            frame_gap_q  <= '0;
        end else begin
            mclk_prev_q  <= mclk_in;
            frame_prev_q <= frame_in;
            if (mclk_in != mclk_prev_q)    mclk_gap_q <= '0;
            else if (mclk_gap_q != GAP_MAX) mclk_gap_q <= mclk_gap_q + 1'b1;
            if (frame_in != frame_prev_q)    frame_gap_q <= '0;
            else if (frame_gap_q != GAP_MAX) frame_gap_q <= frame_gap_q + 1'b1;
        end
    end

    AST_PD_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_n && $past(!pwr_dn_n) && $past(!pwr_dn_n, 2)) |=> (core_rst && zero_force && !ready)); // R1

    AST_READY_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(init_cnt) == LAST)); // R2

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        init_cnt <= LAST); // R2

    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (zero_force && !ready)); // R4

    AST_MCLK_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_gap_q >= GAP_DEAD) |-> !ready); // R5

    AST_FRAME_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_gap_q >= GAP_DEAD) |-> !ready); // R5

endmodule

bind pwrup_seq pwrup_seq_chk #(
    .INIT_FRAMES (INIT_FRAMES),
    .CLK_TIMEOUT (CLK_TIMEOUT),
    .CNT_W       (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn_n   (pwr_dn_n),
    .mclk_in    (mclk_in),
    .frame_in   (frame_in),
    .core_rst   (core_rst),
    .zero_force (zero_force),
    .ready      (ready),
    .init_cnt   (init_cnt)
);

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;

    localparam int SW      = 24;
    localparam int NFR     = 4129;
    localparam int TOUT    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_dn_n = 1'b0;
    logic          mclk_in = 1'b0;
    logic          frame_in = 1'b0;
    logic          fmt_i2s = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic          core_rst, zero_force, ready;
    logic [SW-1:0] sample_out;

    int  checks = 0;
    int  errors = 0;
    bit  mclk_run = 0, frame_run = 0, edge_now = 0;
    int  fph = 0;
    int  n_edges = 0;

    always #2.5 clk = ~clk;

    pwrup_seq #(.SAMPLE_W(SW), .INIT_FRAMES(NFR), .CLK_TIMEOUT(TOUT)) i_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .mclk_in(mclk_in),
        .frame_in(frame_in), .fmt_i2s(fmt_i2s), .sample_in(sample_in),
        .core_rst(core_rst), .zero_force(zero_force), .ready(ready),
        .sample_out(sample_out)
    );

    // expected {core_rst, zero_force, ready}: 0 = off, 1 = waiting/initializing, 2 = run
    function automatic logic [2:0] exp_flags(int mode);
        case (mode)
            0:       return 3'b110;
            1:       return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [SW-1:0] exp_sample(logic zf, logic [SW-1:0] din);
        return zf ? '0 : din;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_flags(string tag, int mode);
        check(tag, {29'd0, core_rst, zero_force, ready}, {29'd0, exp_flags(mode)});
    endtask

    task automatic tick();
        logic nf;
        @(negedge clk);
        edge_now = 0;
        if (mclk_run) mclk_in = ~mclk_in;
        if (frame_run) begin
            fph = (fph + 1) % 8;
            nf  = (fph < 4);
            if (fmt_i2s ? (frame_in && !nf) : (!frame_in && nf)) edge_now = 1;
            frame_in = nf;
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic release_aligned();
        do tick(); while (!edge_now);
        pwr_dn_n = 1'b1;
        n_edges  = 0;
    endtask

    task automatic count_to(int n);
        while (n_edges < n) begin
            tick();
            if (edge_now) n_edges++;
        end
    endtask

    task automatic full_init(string tag);
        release_aligned();
        count_to(NFR - 1);
        ticks(6);
        check_flags({tag, " one edge short"}, 1);
        count_to(NFR);
        ticks(2);
        check_flags({tag, " two cycles after last edge"}, 1);
        tick();
        check_flags({tag, " third cycle after last edge"}, 2);
    endtask

    task automatic random_samples(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            sample_in = SW'($urandom);
            #1;
            check("R6 pass-through", {8'd0, sample_out}, {8'd0, exp_sample(zero_force, sample_in)});
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        sample_in = 24'hABCDEF;
        ticks(4);
        rst_n = 1'b1;
        ticks(3);
        check_flags("R7 reset flags", 0);
        check("R7 reset sample", {8'd0, sample_out}, 32'd0);

        // release with no clocks
        pwr_dn_n = 1'b1;
        ticks(200);
        check_flags("R4 no clocks", 1);
        check("R6 zero while waiting", {8'd0, sample_out}, {8'd0, exp_sample(1'b1, sample_in)});
        mclk_run = 1;
        ticks(200);
        check_flags("R4 frame clock absent", 1);

        pwr_dn_n = 1'b0;
        ticks(3);
        check_flags("R1 power-down from wait", 0);
        frame_run = 1;
        ticks(100);
        check_flags("R1 held with clocks", 0);

        // rising-edge count
        fmt_i2s = 1'b0;
        full_init("R2");
        random_samples(20);

        // frame clock loss in run
        frame_run = 0;
        ticks(TOUT + 10);
        check_flags("R5 frame clock lost", 1);
        check("R6 zero after loss", {8'd0, sample_out}, 32'd0);
        frame_run = 1;
        ticks(40);
        check_flags("R5 no instant resume", 1);

        pwr_dn_n = 1'b0;
        ticks(3);
        check_flags("R1 power-down from init", 0);

        // falling-edge count
        fmt_i2s = 1'b1;
        ticks(20);
        full_init("R3");
        random_samples(10);

        // master clock loss in run
        mclk_run = 0;
        ticks(TOUT + 10);
        check_flags("R5 master clock lost", 1);
        mclk_run = 1;
        pwr_dn_n = 1'b0;
        ticks(3);
        check_flags("R1 power-down after loss", 0);

        // power-down in the middle of init clears the count
        fmt_i2s = 1'b0;
        ticks(100);
        release_aligned();
        count_to(2000);
        pwr_dn_n = 1'b0;
        ticks(3);
        check_flags("R1 power-down mid init", 0);
        ticks(10);
        full_init("R1 count restarted");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule